// File: doc/BRIEF.md
# External Bus Byte-Lane Controller

This block connects an internal memory-request port to a 16-bit external data bus that may also be run 8 bits wide. For each access it works out the width of the bus from two width-configuration inputs and, when both are set, from a live bus-width pin. It then drives the byte strobes and the address LSB for the access. A word access on an 8-bit bus is split into two back-to-back byte cycles, and the read word is put back together from both cycles.

The upper-byte output has two meanings, chosen by a mode input. In enable mode it is an active-low high-byte enable: it marks every cycle that moves data on the upper half of the bus. In strobe mode it is an active-low high-byte write strobe. The ordinary write strobe then covers only the low byte. Each bus cycle lasts one clock. Wait states, address latching and pin sharing belong to other blocks.

Top module: `bus_lane_ctrl`

## Requirements
- R1: The bus width is decoded from {cfg_wid_a, cfg_wid_b}. 2'b01 gives a fixed 8-bit bus and 2'b10 gives a fixed 16-bit bus; in both cases bus_wide_in has no effect. 2'b11 lets bus_wide_in choose: 1 means 16-bit and 0 means 8-bit. 2'b00 gives 8-bit.
- R2: The width is sampled on the clock edge that accepts the request and is held for every bus cycle of that access, even if bus_wide_in changes later.
- R3: When cfg_strobe_mode = 1 (enable mode) on a 16-bit bus, bus_hi_n is low during a word access or an odd-address byte access, and high during an even-address byte access. The pair (bus_hi_n, bus_addr[0]) therefore reads (0,0) for both bytes, (0,1) for the high byte only and (1,0) for the low byte only.
- R4: When cfg_strobe_mode = 0 (strobe mode), bus_hi_n is low only in 16-bit write cycles that write the high byte. It stays high on every read.
- R5: bus_wr_n is low in every write cycle in enable mode. In strobe mode it is low only when the low lane, bus_dout[7:0], is written: any 8-bit cycle, or a 16-bit word or even-address byte write. bus_rd_n and bus_wr_n are never low together.
- R6: On an 8-bit bus, bus_hi_n stays high, and all data moves on lane [7:0]. bus_din[15:8] is ignored.
- R7: A word access on an 8-bit bus takes two cycles. The first cycle uses bus_addr[0] = 0 and carries the low byte; the second uses bus_addr[0] = 1 and carries the high byte. rsp_done pulses once, after the second cycle, and rsp_rdata = {second byte, first byte}.
- R8: On a 16-bit bus, a word read returns bus_din unchanged. A byte read returns in rsp_rdata[7:0], with the upper byte zero. The byte comes from bus_din[15:8] when the address is odd and from bus_din[7:0] when it is even.
- R9: A request is accepted on a rising edge where req_valid and req_ready are both high. req_ready is high only while no access is in progress. The first bus cycle (bus_cyc = 1) follows in the next clock. rsp_done is a one-clock pulse in the clock after the last bus cycle. bus_addr[AW-1:1] follows req_addr, and req_addr[0] is ignored for word accesses.
- R10: A 16-bit word write drives req_wdata onto bus_dout. A byte write drives req_wdata[7:0] on both lanes. An 8-bit word write drives req_wdata[7:0] and then req_wdata[15:8] on both lanes.
- R11: Out of reset and between accesses, bus_cyc is low, req_ready is high, rsp_done is low, and bus_hi_n, bus_wr_n and bus_rd_n are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Ready to accept a request |
| req_addr | input | AW | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Access finished (one-clock pulse) |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| cfg_strobe_mode | input | 1 | 1 = high-byte enable, 0 = high-byte write strobe |
| cfg_wid_a | input | 1 | Width configuration bit A |
| cfg_wid_b | input | 1 | Width configuration bit B |
| bus_wide_in | input | 1 | Bus-width pin, 1 = 16-bit |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_addr | output | AW | Bus address; bit 0 is the address LSB |
| bus_hi_n | output | 1 | Upper-byte enable or upper-byte write strobe |
| bus_wr_n | output | 1 | Write strobe |
| bus_rd_n | output | 1 | Read strobe |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |

## Verification
The bench tries every combination of the width-configuration pair, pin level, upper-byte mode, read or write, word or byte size, and even or odd address. It checks that the number of cycles per access tells a fixed width apart from a pin-selected one. The strobes and bus_addr[0] in each cycle tell enable mode apart from strobe mode, and they also show which byte lane is in use. When the pair is 2'b11, the bench flips the pin right after the request is accepted, so a width that is sampled too late changes the cycle count. The read model puts a marker value on the upper lane of an 8-bit bus, and it gives each byte address its own value, so a wrong lane or a wrong byte order shows up in rsp_rdata.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_e;

  // 1 = 16-bit bus for this access
  function automatic logic decode_wide(input logic cfg_a, input logic cfg_b,
                                       input logic pin);
    logic r;
    case ({cfg_a, cfg_b})
      2'b10:   r = 1'b1;
      2'b11:   r = pin;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/blc_rst_sync.sv
module blc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= 1'b1;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/blc_width_sel.sv
module blc_width_sel (
  input  logic cfg_wid_a,
  input  logic cfg_wid_b,
  input  logic bus_wide_in,
  output logic wide_now
);
  import blc_pkg::*;

  always_comb begin
    wide_now = decode_wide(cfg_wid_a, cfg_wid_b, bus_wide_in);
  end
endmodule

// File: rtl/blc_seq.sv
module blc_seq #(
  parameter int AW = 16,
  parameter int BW = 8,
  localparam int DW = 2*BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          wide_now,
  input  logic [DW-1:0] bus_din,
  output logic          req_ready,
  output logic          cyc_active,
  output logic          cyc_second,
  output logic [AW-1:0] q_addr,
  output logic          q_word,
  output logic          q_write,
  output logic [DW-1:0] q_wdata,
  output logic          q_wide,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done
);
  import blc_pkg::*;

  seq_state_e st_q, st_d;
  logic          cap_en, lo_en, done_d;
  logic [BW-1:0] lo_q;
  logic [DW-1:0] rdata_d;
  logic [BW-1:0] lane_lo, lane_hi;

  assign lane_lo = bus_din[BW-1:0];
  assign lane_hi = bus_din[DW-1:BW];

  // next-state
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    lo_en   = 1'b0;
    done_d  = 1'b0;
    rdata_d = rsp_rdata;
    case (st_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          st_d   = SEQ_FIRST;
          cap_en = 1'b1;
        end
      end
      SEQ_FIRST: begin
        if (q_word && !q_wide) begin
          st_d  = SEQ_SECOND;
          lo_en = 1'b1;
        end else begin
          st_d   = SEQ_IDLE;
          done_d = 1'b1;
          if (q_wide && q_word)        rdata_d = bus_din;
          else if (q_wide && q_addr[0]) rdata_d = {{BW{1'b0}}, lane_hi};
          else                          rdata_d = {{BW{1'b0}}, lane_lo};
        end
      end
      SEQ_SECOND: begin
        st_d    = SEQ_IDLE;
        done_d  = 1'b1;
        rdata_d = {lane_lo, lo_q};
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      rsp_done <= 1'b0;
    end else begin
      st_q     <= st_d;
      rsp_done <= done_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      q_addr  <= req_addr;
      q_word  <= req_word;
      q_write <= req_write;
      q_wdata <= req_wdata;
      q_wide  <= wide_now;
    end
    if (lo_en)  lo_q      <= lane_lo;
    if (done_d) rsp_rdata <= rdata_d;
  end

  assign req_ready  = (st_q == SEQ_IDLE);
  assign cyc_active = (st_q != SEQ_IDLE);
  assign cyc_second = (st_q == SEQ_SECOND);
endmodule

// File: rtl/blc_lane_drv.sv
module blc_lane_drv #(
  parameter int AW = 16,
  parameter int BW = 8,
  localparam int DW = 2*BW
) (
  input  logic          cyc_active,
  input  logic          cyc_second,
  input  logic [AW-1:0] q_addr,
  input  logic          q_word,
  input  logic          q_write,
  input  logic [DW-1:0] q_wdata,
  input  logic          q_wide,
  input  logic          strobe_mode,
  output logic [AW-1:0] bus_addr,
  output logic          bus_hi_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [DW-1:0] bus_dout
);
  logic          hi_touch, lo_touch, a0;
  logic [BW-1:0] byte_sel;

  always_comb begin
    hi_touch = q_word | q_addr[0];
    lo_touch = q_word | ~q_addr[0];
    a0       = q_word ? cyc_second : q_addr[0];
    bus_addr = {q_addr[AW-1:1], a0};
    bus_rd_n = ~(cyc_active & ~q_write);

    if (q_wide) begin
      if (strobe_mode) begin
        bus_hi_n = ~(cyc_active & hi_touch);
        bus_wr_n = ~(cyc_active & q_write);
      end else begin
        bus_hi_n = ~(cyc_active & q_write & hi_touch);
        bus_wr_n = ~(cyc_active & q_write & lo_touch);
      end
    end else begin
      bus_hi_n = 1'b1;
      bus_wr_n = ~(cyc_active & q_write);
    end

    byte_sel = (q_word && cyc_second) ? q_wdata[DW-1:BW] : q_wdata[BW-1:0];
    if (q_wide && q_word) bus_dout = q_wdata;
    else                  bus_dout = {byte_sel, byte_sel};
  end
endmodule

// File: rtl/bus_lane_ctrl.sv
module bus_lane_ctrl #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW = 2*BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  input  logic          cfg_strobe_mode,
  input  logic          cfg_wid_a,
  input  logic          cfg_wid_b,
  input  logic          bus_wide_in,
  output logic          bus_cyc,
  output logic [AW-1:0] bus_addr,
  output logic          bus_hi_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);
  logic          rst_s;
  logic          wide_now;
  logic          cyc_second;
  logic [AW-1:0] q_addr;
  logic          q_word, q_write, q_wide;
  logic [DW-1:0] q_wdata;

  blc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  blc_width_sel u_wsel (
    .cfg_wid_a(cfg_wid_a), .cfg_wid_b(cfg_wid_b),
    .bus_wide_in(bus_wide_in), .wide_now(wide_now)
  );

  blc_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_s),
    .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
    .req_write(req_write), .req_wdata(req_wdata),
    .wide_now(wide_now), .bus_din(bus_din),
    .req_ready(req_ready), .cyc_active(bus_cyc), .cyc_second(cyc_second),
    .q_addr(q_addr), .q_word(q_word), .q_write(q_write),
    .q_wdata(q_wdata), .q_wide(q_wide),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
  );

  blc_lane_drv #(.AW(AW), .BW(BW)) u_lane (
    .cyc_active(bus_cyc), .cyc_second(cyc_second),
    .q_addr(q_addr), .q_word(q_word), .q_write(q_write),
    .q_wdata(q_wdata), .q_wide(q_wide), .strobe_mode(cfg_strobe_mode),
    .bus_addr(bus_addr), .bus_hi_n(bus_hi_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_dout(bus_dout)
  );
endmodule

// File: rtl/bus_lane_ctrl_chk.sv
module bus_lane_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic cfg_strobe_mode,
  input logic cfg_wid_a,
  input logic cfg_wid_b,
  input logic bus_cyc,
  input logic bus_hi_n,
  input logic bus_wr_n,
  input logic bus_rd_n
);
  // R4
  hi_quiet_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !cfg_strobe_mode) |-> bus_hi_n);

  // R11
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (bus_hi_n && bus_rd_n && bus_wr_n));

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R6
  narrow_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !cfg_wid_a && cfg_wid_b) |-> bus_hi_n);

  // R9
  accept_to_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_cyc);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind bus_lane_ctrl bus_lane_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .cfg_strobe_mode(cfg_strobe_mode),
  .cfg_wid_a(cfg_wid_a), .cfg_wid_b(cfg_wid_b), .bus_cyc(bus_cyc),
  .bus_hi_n(bus_hi_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
);

// File: tb/bus_lane_ctrl_test.sv
`timescale 1ns/1ps
module bus_lane_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_word, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        cfg_strobe_mode, cfg_wid_a, cfg_wid_b, bus_wide_in;
  logic        bus_cyc, bus_hi_n, bus_wr_n, bus_rd_n;
  logic [15:0] bus_addr, bus_dout, bus_din;
  logic        tb_wide;

  always #10 clk = ~clk;

  bus_lane_ctrl uut (.*);

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_din = tb_wide ? {mb(bus_addr | 16'h1), mb(bus_addr & 16'hFFFE)}
                           : {8'hEE, mb(bus_addr)};

  typedef struct {
    logic [15:0] addr;
    logic        hi_n, wr_n, rd_n;
    logic [15:0] dout, dmask;
    string       tag_a, tag_hi;
  } cyc_t;
  typedef struct {
    logic [15:0] rdata;
    logic        chk_rd;
    int          ncyc;
    string       tag_rd, tag_n;
  } rsp_t;

  cyc_t cq[$];
  rsp_t rq[$];
  int   n_cmp = 0, n_bad = 0, ncyc = 0;
  logic running = 1'b0, finished = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (bus_cyc) begin
        ncyc++;
        if (cq.size() == 0) begin
          check("R9", "unexpected bus cycle", 16'd1, 16'd0);
        end else begin
          cyc_t e;
          e = cq.pop_front();
          check(e.tag_a, "bus_addr", bus_addr, e.addr);
          check(e.tag_hi, "bus_hi_n", {15'd0, bus_hi_n}, {15'd0, e.hi_n});
          check("R5", "bus_wr_n", {15'd0, bus_wr_n}, {15'd0, e.wr_n});
          check("R9", "bus_rd_n", {15'd0, bus_rd_n}, {15'd0, e.rd_n});
          check("R10", "bus_dout", bus_dout & e.dmask, e.dout & e.dmask);
          check("R9", "req_ready busy", {15'd0, req_ready}, 16'd0);
        end
      end else begin
        // R11 idle strobes
        check("R11", "idle strobes", {13'd0, bus_hi_n, bus_wr_n, bus_rd_n}, 16'd7);
      end
      if (rsp_done) begin
        if (rq.size() == 0) begin
          check("R9", "unexpected done", 16'd1, 16'd0);
        end else begin
          rsp_t r;
          r = rq.pop_front();
          check(r.tag_n, "cycles per access", ncyc[15:0], r.ncyc[15:0]);
          if (r.chk_rd) check(r.tag_rd, "rsp_rdata", rsp_rdata, r.rdata);
        end
        ncyc = 0;
      end
    end
  end

  // driver: computes expectations, then issues the request
  task automatic access(input logic [1:0] cfg, input logic pin, input logic mode,
                        input logic [15:0] addr, input logic word,
                        input logic write, input logic [15:0] wdata,
                        input logic flip);
    logic wide, a0, th, tl;
    cyc_t e;
    rsp_t r;
    case (cfg)
      2'b10:   wide = 1'b1;
      2'b11:   wide = pin;
      default: wide = 1'b0;
    endcase
    e.rd_n  = write;
    e.tag_a = (word && !wide) ? "R7" : "R9";
    r.chk_rd = !write;
    r.tag_n  = (cfg == 2'b11) ? "R2" : "R1";
    r.tag_rd = (word && !wide) ? "R7" : "R8";
    if (wide) begin
      a0 = word ? 1'b0 : addr[0];
      th = word | a0;
      tl = word | ~a0;
      e.addr   = {addr[15:1], a0};
      e.hi_n   = mode ? ~th : ~(write & th);
      e.wr_n   = !write ? 1'b1 : (mode ? 1'b0 : ~tl);
      e.tag_hi = mode ? "R3" : "R4";
      e.dout   = word ? wdata : {wdata[7:0], wdata[7:0]};
      e.dmask  = write ? 16'hFFFF : 16'h0000;
      cq.push_back(e);
      r.ncyc  = 1;
      r.rdata = word ? {mb(addr | 16'h1), mb(addr & 16'hFFFE)} : {8'h00, mb(addr)};
    end else begin
      e.hi_n   = 1'b1;
      e.wr_n   = ~write;
      e.tag_hi = "R6";
      e.dmask  = write ? 16'hFFFF : 16'h0000;
      if (word) begin
        e.addr = {addr[15:1], 1'b0};
        e.dout = {wdata[7:0], wdata[7:0]};
        cq.push_back(e);
        e.addr = {addr[15:1], 1'b1};
        e.dout = {wdata[15:8], wdata[15:8]};
        cq.push_back(e);
        r.ncyc  = 2;
        r.rdata = {mb(addr | 16'h1), mb(addr & 16'hFFFE)};
      end else begin
        e.addr = addr;
        e.dout = {wdata[7:0], wdata[7:0]};
        cq.push_back(e);
        r.ncyc  = 1;
        r.rdata = {8'h00, mb(addr)};
      end
    end
    rq.push_back(r);

    @(negedge clk);
    {cfg_wid_a, cfg_wid_b} = cfg;
    bus_wide_in     = pin;
    cfg_strobe_mode = mode;
    tb_wide         = wide;
    req_addr        = addr;
    req_word        = word;
    req_write       = write;
    req_wdata       = wdata;
    req_valid       = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) bus_wide_in = ~pin;
    while (!rsp_done) @(negedge clk);
  endtask

  initial begin
    int k;
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_word = 1'b0; req_write = 1'b0;
    req_wdata = '0; cfg_strobe_mode = 1'b1; cfg_wid_a = 1'b1; cfg_wid_b = 1'b0;
    bus_wide_in = 1'b1; tb_wide = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11", "reset req_ready", {15'd0, req_ready}, 16'd1);
    check("R11", "reset bus_cyc", {15'd0, bus_cyc}, 16'd0);
    check("R11", "reset rsp_done", {15'd0, rsp_done}, 16'd0);
    check("R11", "reset strobes", {13'd0, bus_hi_n, bus_wr_n, bus_rd_n}, 16'd7);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    k = 0;
    for (int cfg = 0; cfg < 4; cfg++)
      for (int pin = 0; pin < 2; pin++)
        for (int mode = 0; mode < 2; mode++)
          for (int wr = 0; wr < 2; wr++)
            for (int wd = 0; wd < 2; wd++)
              for (int odd = 0; odd < 2; odd++) begin
                access(cfg[1:0], pin[0], mode[0],
                       (16'h2000 + 16'(k * 20)) | {15'd0, odd[0]},
                       wd[0], wr[0], 16'hA1C3 + 16'(k * 37), cfg == 3);
                k++;
              end
    repeat (3) @(negedge clk);
    check("R9", "leftover cycles", 16'(cq.size()), 16'd0);
    check("R9", "leftover responses", 16'(rq.size()), 16'd0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule